// File: doc/BRIEF.md
# LIN Slave Baud-Rate Synchronizer

This block lets a LIN slave node re-derive its receive bit rate from each frame header. It watches the serial receive line and first looks for a long dominant (low) period. It judges that period against the divider currently in force. Once a valid break has ended, the next falling edge is taken as the start bit of the 0x55 synch byte. From that edge the block counts sampling ticks until the falling edge that opens the last data bit, which lies exactly eight bit times later.

The count is never divided. Its upper bits become the new integer divider and its three lowest bits become the fractional part, in eighths. Both are written into the divider register together, with a one-cycle load strobe. Until the first successful load, the divider outputs follow the initial-value inputs. A measurement that runs the counter into its ceiling is abandoned, and a one-cycle failure pulse is raised in its place.

The block runs on the fast clock that feeds the baud generator. One measurement tick lasts 8 or 16 of those clocks, as set by the oversampling select. The stored integer divider is therefore the number of fast clocks per oversample period.

Top module: `lin_baud_sync`

## Requirements
- R1: While `slave_en` is 0, no break is detected and no load or failure pulse occurs. Dropping `slave_en` in mid-header returns the block to idle without a load.
- R2: `rxd` passes through two synchronizing flops, and edges are detected on the synchronized line. A falling transition of `rxd` sampled at clock edge k acts on the state machine at edge k+2, so `div_load` is high after edge k+2 when that transition ends the measurement.
- R3: A low period of L clocks (as seen on the synchronized line) is a valid break when 8*L >= 13*F*(8*D+P). Here D and P are the current `div_int` and `div_frac`, and F is 8 when `ovs8`=1 and 16 when `ovs8`=0. A shorter low period returns the block to idle, and no load follows.
- R4: After a valid break has ended, the first falling edge starts a new measurement with the tick counter cleared, however long the delimiter lasted.
- R5: The tick counter advances once every F clocks, where F is the oversampling factor of R3. If the fifth falling edge arrives N clocks after the start edge, the final count is floor(N/F).
- R6: At the fifth falling edge (the start edge counts as the first), `div_int` takes count>>3 and `div_frac` takes count[2:0]. `div_load` is high for exactly one cycle, the same cycle the new values appear.
- R7: Before the first load, `div_int`/`div_frac` equal `div_int_init`/`div_frac_init` and follow them. After a load, they change only on a further load.
- R8: If the tick counter reaches its all-ones ceiling (2^MEAS_W-1), the measurement ends. `sync_fail` pulses for one cycle, no load occurs and the block returns to idle.
- R9: Each new header is judged against the divider stored by the previous load, and a new synch byte replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that feeds the baud generator |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Node is configured as a LIN slave; enables synchronization |
| ovs8 | input | 1 | Oversampling select: 1 = 8 clocks per tick, 0 = 16 |
| rxd | input | 1 | Asynchronous serial receive line |
| div_int_init | input | MEAS_W-3 | Integer divider in force before the first load |
| div_frac_init | input | 3 | Fractional divider (eighths) in force before the first load |
| div_int | output | MEAS_W-3 | Current integer divider |
| div_frac | output | 3 | Current fractional divider |
| div_load | output | 1 | One-cycle strobe: new divider values stored |
| sync_fail | output | 1 | One-cycle pulse: measurement abandoned on counter saturation |

## Verification
Some rules hold on every cycle, and the assertions check those. The stored divider must equal the tick count captured one cycle earlier whenever `div_load` is high. The strobe and the failure pulse must last a single cycle and never occur together, and a saturated count must be followed by a failure. The divider must not move between loads, and a disabled slave must never load. The break threshold, the floor(N/F) tick arithmetic and the two-flop latency only show over a whole header. The bench's cycle-accurate model and its scenarios cover these: boundary break lengths, both oversampling factors, long delimiters, an abort in mid-byte and a synch byte whose fifth edge never arrives.

// File: rtl/lin_baud_sync_pkg.sv
package lin_baud_sync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BREAK   = 2'd1,
    ST_DELIM   = 2'd2,
    ST_MEASURE = 2'd3
  } sync_state_t;

  // Last prescaler value of one tick: F-1 clocks.
  function automatic logic [3:0] ovs_last(input logic ovs8);
    return ovs8 ? 4'd7 : 4'd15;
  endfunction

  // Break test: 8*L >= 13*F*(8*D+P); div_eighths carries 8*D+P.
  function automatic logic brk_long_enough(input logic [31:0] low_len,
                                           input logic [31:0] div_eighths,
                                           input logic        ovs8);
    logic [39:0] lhs;
    logic [39:0] rhs;
    lhs = {5'd0, low_len, 3'd0};
    rhs = 40'(div_eighths) * 40'(ovs8 ? 8'd104 : 8'd208);
    return lhs >= rhs;
  endfunction

endpackage

// File: rtl/lbs_rx_edge.sv
module lbs_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic fall_o,
  output logic rise_o
);
  logic meta_q;
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rxd;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall_o = prev_q & ~sync_q;
  assign rise_o = ~prev_q & sync_q;
endmodule

// File: rtl/lbs_break_judge.sv
module lbs_break_judge #(
  parameter int LOW_W = 24,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic             ovs8_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [2:0]       frac_i,
  output logic             pass_o,
  output logic             reject_o
);
  import lin_baud_sync_pkg::*;

  localparam logic [LOW_W-1:0] LOW_MAX = '1;

  logic [LOW_W-1:0] low_q;
  logic             long_enough;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (start_i) begin
      low_q <= LOW_W'(1);
    end else if (run_i && !rise_i && low_q != LOW_MAX) begin
      low_q <= low_q + 1'b1;
    end
  end

  assign long_enough = brk_long_enough(32'(low_q), 32'({div_i, frac_i}), ovs8_i);
  assign pass_o      = run_i & rise_i & long_enough;
  assign reject_o    = run_i & rise_i & ~long_enough;
endmodule

// File: rtl/lbs_window_counter.sv
module lbs_window_counter #(
  parameter int MEAS_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              ovs8_i,
  output logic [MEAS_W-1:0] count_next_o,
  output logic              sat_o
);
  import lin_baud_sync_pkg::*;

  localparam logic [MEAS_W-1:0] CNT_MAX = '1;

  logic [3:0]        pre_q;
  logic [MEAS_W-1:0] cnt_q;
  logic              tick;

  assign tick         = run_i && (pre_q == ovs_last(ovs8_i));
  assign count_next_o = (tick && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  assign sat_o        = run_i && (count_next_o == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      pre_q <= tick ? 4'd0 : pre_q + 4'd1;
      cnt_q <= count_next_o;
    end
  end
endmodule

// File: rtl/lin_baud_sync.sv
module lin_baud_sync #(
  parameter  int MEAS_W = 19,
  localparam int DIV_W  = MEAS_W - 3,
  localparam int LOW_W  = MEAS_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic             ovs8,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div_int_init,
  input  logic [2:0]       div_frac_init,
  output logic [DIV_W-1:0] div_int,
  output logic [2:0]       div_frac,
  output logic             div_load,
  output logic             sync_fail
);
  import lin_baud_sync_pkg::*;

  sync_state_t       st_q, st_d;
  logic              fall, rise;
  logic              brk_start, brk_run, brk_pass, brk_reject;
  logic              meas_start, measuring, meas_done, meas_sat;
  logic [MEAS_W-1:0] meas_count;
  logic [2:0]        edge_q;
  logic [DIV_W-1:0]  div_q;
  logic [2:0]        frac_q;
  logic              loaded;
  logic              load_q, fail_q;

  lbs_rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd    (rxd),
    .fall_o (fall),
    .rise_o (rise)
  );

  assign brk_start  = slave_en && st_q == ST_IDLE && fall;
  assign brk_run    = slave_en && st_q == ST_BREAK;
  assign meas_start = slave_en && st_q == ST_DELIM && fall;
  assign measuring  = slave_en && st_q == ST_MEASURE;

  lbs_break_judge #(.LOW_W(LOW_W), .DIV_W(DIV_W)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (brk_start),
    .run_i    (brk_run),
    .rise_i   (rise),
    .ovs8_i   (ovs8),
    .div_i    (div_int),
    .frac_i   (div_frac),
    .pass_o   (brk_pass),
    .reject_o (brk_reject)
  );

  lbs_window_counter #(.MEAS_W(MEAS_W)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (meas_start),
    .run_i        (measuring),
    .ovs8_i       (ovs8),
    .count_next_o (meas_count),
    .sat_o        (meas_sat)
  );

  assign meas_done = measuring && fall && edge_q == 3'd4 && !meas_sat;

  always_comb begin
    st_d = st_q;
    if (!slave_en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    if (fall) st_d = ST_BREAK;
        ST_BREAK: begin
          if (brk_pass)        st_d = ST_DELIM;
          else if (brk_reject) st_d = ST_IDLE;
        end
        ST_DELIM:   if (fall) st_d = ST_MEASURE;
        ST_MEASURE: if (meas_sat || meas_done) st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
    end else begin
      st_q <= st_d;
      if (meas_start)             edge_q <= 3'd1;
      else if (measuring && fall) edge_q <= edge_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      frac_q <= '0;
      loaded <= 1'b0;
      load_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      load_q <= meas_done;
      fail_q <= meas_sat;
      if (meas_done) begin
        div_q  <= meas_count[MEAS_W-1:3];
        frac_q <= meas_count[2:0];
        loaded <= 1'b1;
      end
    end
  end

  assign div_int   = loaded ? div_q  : div_int_init;
  assign div_frac  = loaded ? frac_q : div_frac_init;
  assign div_load  = load_q;
  assign sync_fail = fail_q;
endmodule

// File: rtl/lin_baud_sync_chk.sv
module lin_baud_sync_chk #(
  parameter int MEAS_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_en,
  input logic [MEAS_W-4:0] div_int,
  input logic [2:0]        div_frac,
  input logic              div_load,
  input logic              sync_fail,
  input logic              meas_sat,
  input logic [MEAS_W-1:0] meas_count,
  input logic              loaded
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: a disabled slave never loads a divider
  assert_no_load_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(slave_en)) |-> !div_load);

  // R6: stored value is the tick count captured on the previous cycle
  assert_load_takes_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && div_load) |-> ({div_int, div_frac} == $past(meas_count)));

  // R6: load strobe lasts a single cycle
  assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> !div_load);

  // R7: divider holds between loads once loaded
  assert_hold_between_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && loaded && $past(loaded) && !div_load) |-> ($stable(div_int) && $stable(div_frac)));

  // R8: saturation yields a failure pulse and no load
  assert_sat_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_sat |=> (sync_fail && !div_load));

  // R8: failure pulse lasts a single cycle and never meets a load
  assert_fail_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fail |=> !sync_fail);

  assert_fail_excl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fail |-> !div_load);
endmodule

bind lin_baud_sync lin_baud_sync_chk #(.MEAS_W(MEAS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slave_en   (slave_en),
  .div_int    (div_int),
  .div_frac   (div_frac),
  .div_load   (div_load),
  .sync_fail  (sync_fail),
  .meas_sat   (meas_sat),
  .meas_count (meas_count),
  .loaded     (loaded)
);

// File: tb/lin_baud_sync_test.sv
`timescale 1ns/100ps
module lin_baud_sync_test;
  localparam int MW   = 12;
  localparam int DW   = MW - 3;
  localparam int CMAX = (1 << MW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slave_en = 1'b1;
  logic          ovs8 = 1'b0;
  logic          rxd = 1'b1;
  logic [DW-1:0] init_d = DW'(7);
  logic [2:0]    init_f = 3'd3;
  logic [DW-1:0] div_int;
  logic [2:0]    div_frac;
  logic          div_load, sync_fail;

  int tests = 0, fails = 0, mism = 0;
  int cyc = 0, last_fall = 0, last_load = 0, loads = 0, fail_cnt = 0;
  logic rx_prev = 1'b1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lin_baud_sync #(.MEAS_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .ovs8(ovs8), .rxd(rxd),
    .div_int_init(init_d), .div_frac_init(init_f),
    .div_int(div_int), .div_frac(div_frac), .div_load(div_load), .sync_fail(sync_fail));

  // behavioural reference model
  int hist[$];
  int m_state, m_low, m_pre, m_cnt, m_edges, m_div, m_frac;
  bit m_loaded, m_upd, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1, 1, 1};
      m_state = 0; m_low = 0; m_pre = 0; m_cnt = 0; m_edges = 0;
      m_div = 0; m_frac = 0; m_loaded = 0; m_upd = 0; m_err = 0;
    end else begin
      bit fe, re;
      int f, cur;
      fe = (hist[2] == 1) && (hist[1] == 0);
      re = (hist[2] == 0) && (hist[1] == 1);
      f = ovs8 ? 8 : 16;
      cur = m_loaded ? (m_div * 8 + m_frac) : (int'(init_d) * 8 + int'(init_f));
      m_upd = 0; m_err = 0;
      if (!slave_en) m_state = 0;
      else begin
        case (m_state)
          0: if (fe) begin m_state = 1; m_low = 1; end
          1: if (re) m_state = (m_low * 8 >= 13 * f * cur) ? 2 : 0;
             else m_low++;
          2: if (fe) begin m_state = 3; m_pre = 0; m_cnt = 0; m_edges = 1; end
          default: begin
            m_pre++;
            if (m_pre == f) begin m_pre = 0; if (m_cnt < CMAX) m_cnt++; end
            if (m_cnt == CMAX) begin m_err = 1; m_state = 0; end
            else if (fe) begin
              m_edges++;
              if (m_edges == 5) begin
                m_div = m_cnt >> 3; m_frac = m_cnt & 7; m_loaded = 1; m_upd = 1; m_state = 0;
              end
            end
          end
        endcase
      end
      hist.push_front(int'(rxd));
      void'(hist.pop_back());
    end
  end

  // per-clock comparison and event monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int ed, ef;
      cyc++;
      ed = m_loaded ? m_div : int'(init_d);
      ef = m_loaded ? m_frac : int'(init_f);
      if (int'(div_int) != ed || int'(div_frac) != ef || div_load != m_upd || sync_fail != m_err)
        mism++;
      if (rx_prev && !rxd) last_fall = cyc;
      rx_prev = rxd;
      if (div_load) begin loads++; last_load = cyc; end
      if (sync_fail) fail_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
    #1;
  endtask

  // break, delimiter, 0x55 with start/stop, trailing idle; abort_bit>=0 drops slave_en
  task automatic frame(input int brk, input int delim, input int b, input int abort_bit);
    logic [9:0] bits;
    bits = {1'b1, 8'h55, 1'b0};
    hold(1'b0, brk);
    hold(1'b1, delim);
    for (int i = 0; i < 10; i++) begin
      if (i == abort_bit) slave_en = 1'b0;
      hold(bits[i], b);
    end
    hold(1'b1, 3 * b);
  endtask

  task automatic expect_div(input int d, input int fr, input string tag);
    check(int'(div_int) == d, tag, int'(div_int), d);
    check(int'(div_frac) == fr, tag, int'(div_frac), fr);
  endtask

  task automatic expect_model(input string tag);
    check(mism == 0, tag, mism, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // reset state, outputs follow initial values (R7)
    check(div_load == 0 && sync_fail == 0, "R7 reset strobes", int'(div_load), 0);
    expect_div(7, 3, "R7 init follows");
    init_d = DW'(10); init_f = 3'd0;
    hold(1'b1, 4);
    expect_div(10, 0, "R7 init change followed");

    // R3 R5 R6: 16x, nominal 160 clk/bit, frame at 164 clk/bit -> count 82
    loads = 0;
    frame(2240, 164, 164, -1);
    expect_div(10, 2, "R6 first sync 16x");
    check(loads == 1, "R6 single load strobe", loads, 1);
    check(last_load - last_fall == 2, "R2 two-flop latency", last_load - last_fall, 2);
    init_d = DW'(1); init_f = 3'd1;
    hold(1'b1, 10);
    expect_div(10, 2, "R7 held after load");
    expect_model("R2 model agreement A");

    // R9 R3: threshold now 13*16*82/8 = 2132 clocks, exact boundary accepted
    loads = 0;
    frame(2132, 200, 200, -1);
    expect_div(12, 4, "R9 resync from stored divider");
    check(loads == 1, "R3 boundary break accepted", loads, 1);

    // R3: threshold 13*16*100/8 = 2600; one clock short is rejected
    loads = 0;
    frame(2599, 200, 120, -1);
    check(loads == 0, "R3 short break rejected", loads, 0);
    expect_div(12, 4, "R3 divider kept after reject");
    expect_model("R3 model agreement");

    // R5 R4: 8x, threshold 1300, long delimiter, 90 clk/bit -> count 90
    ovs8 = 1'b1;
    loads = 0;
    frame(1400, 700, 90, -1);
    expect_div(11, 2, "R5 8x oversampling result");
    check(loads == 1, "R4 long delimiter ignored", loads, 1);

    // R1: disabled slave ignores a full header
    slave_en = 1'b0;
    loads = 0;
    frame(1400, 90, 120, -1);
    check(loads == 0, "R1 disabled no load", loads, 0);
    expect_div(11, 2, "R1 divider kept while disabled");
    slave_en = 1'b1;
    hold(1'b1, 20);

    // R1: drop enable in mid synch byte
    loads = 0;
    frame(1400, 90, 120, 4);
    check(loads == 0, "R1 abort mid byte", loads, 0);
    slave_en = 1'b1;
    hold(1'b1, 20);
    expect_div(11, 2, "R1 divider kept after abort");
    expect_model("R1 model agreement");

    // R8: start bit then no further edges -> saturation at 4095 ticks
    loads = 0; fail_cnt = 0;
    hold(1'b0, 1300);
    hold(1'b1, 90);
    hold(1'b0, 90);
    hold(1'b1, 33200);
    check(fail_cnt == 1, "R8 single failure pulse", fail_cnt, 1);
    check(loads == 0, "R8 no load on saturation", loads, 0);
    expect_div(11, 2, "R8 divider kept");

    // R8 recovery, R9: next header still synchronizes (8x, 96 clk/bit -> 96)
    loads = 0;
    frame(1400, 96, 96, -1);
    expect_div(12, 0, "R8 recovery after failure");
    expect_model("R6 model agreement final");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule